// File: doc/BRIEF.md
# Set/Clear Clock Gating Controller

This block produces the clock enable signals for one processor core clock and for a bank of peripheral clocks. Software reaches it through a small register port. Each clock domain has three registers. A write-one-to-enable register turns clocks on. A write-one-to-disable register turns clocks off. A read-only status register shows which clocks are running. The enables are meant to drive glitch-free gate cells that sit outside this block.

Peripheral clocks follow their enable and disable writes at the next clock edge. Nothing in the peripheral's state is reset when its clock goes off, so the peripheral picks up where it stopped once the clock returns.

The core clock is handled differently. A disable request is held pending until the core signals that an instruction has completed, and only then is the core enable dropped. The pending state is offered to the core on an output. Any interrupt that the interrupt controller has already qualified as enabled turns the core clock back on. Such an interrupt also cancels a stop that has not yet taken effect.

Register map, as byte offsets on the address port:

| Offset | Register |
|---|---|
| 0x00 | core enable |
| 0x04 | core disable |
| 0x08 | core status |
| 0x10 | peripheral enable |
| 0x14 | peripheral disable |
| 0x18 | peripheral status |

Top module: `clock_gate_ctrl`

## Requirements
- R1: During and after reset, with no further stimulus, `core_clk_en` is 1, `core_stop_pend` is 0 and every bit of `periph_clk_en` is 0.
- R2: A write to offset 0x00 with data bit 0 set makes `core_clk_en` 1 and `core_stop_pend` 0 at the next clock edge, which cancels any pending stop. If data bit 0 is clear, the write has no effect.
- R3: A write to offset 0x04 with data bit 0 set while the core clock runs sets `core_stop_pend` at the next edge. `core_clk_en` stays 1 until an edge at which `insn_done` is high while the stop is pending. At that edge `core_clk_en` drops to 0 and `core_stop_pend` clears. `insn_done` has no effect when no stop is pending.
- R4: An edge at which `irq_req` is high leaves `core_clk_en` at 1 and `core_stop_pend` at 0. This holds even if a core disable write or `insn_done` falls on the same cycle, so the enable wins.
- R5: A write to offset 0x10 sets, at the next edge, every implemented peripheral enable whose data bit is 1. Bits written as 0 are left unchanged.
- R6: A write to offset 0x14 clears, at the next edge, every peripheral enable whose data bit is 1. This does not wait for an instruction boundary. Bits written as 0 are left unchanged.
- R7: While `bus_rd` is high, `bus_rdata` shows status without delay. Offset 0x08 returns bit 0 = core clock enabled and bit 1 = stop pending. Offset 0x18 returns the peripheral enables in bits NUM_PERIPH-1:0. Every other offset, including the enable and disable registers, reads 0. While `bus_rd` is low, `bus_rdata` is 0.
- R8: Peripheral enable bit i serves the peripheral whose interrupt source number is i. The lowest RSVD_LOW positions (default 2) are interrupt sources with no clock of their own. Those positions can never be set and always read 0.
- R9: Stopping, pending or waking the core clock never changes `periph_clk_en`, so the transfer engine's clock keeps running while the core is halted. The peripheral enables change only on peripheral enable or disable writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| irq_req | input | 1 | An enabled interrupt is asserted |
| insn_done | input | 1 | The core has completed an instruction |
| core_clk_en | output | 1 | Core clock gate enable |
| core_stop_pend | output | 1 | Core stop waiting for an instruction boundary |
| periph_clk_en | output | NUM_PERIPH | Peripheral clock gate enables |

## Verification
The core clock logic can receive conflicting commands in the same cycle. A disable write can coincide with an enabled interrupt. A pending stop can meet `insn_done` and `irq_req` together. A stop can complete in the same cycle as a new disable write. Directed cases force each of these coincidences. Random stimulus then drives `irq_req` and `insn_done` at independent rates alongside bus traffic. A reference model applies the stated priority: wake first, then explicit enable, then the instruction-boundary stop, then a new request. Each collision is judged on both `core_clk_en` and `core_stop_pend`, and on the peripheral enables left untouched.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

   // Register offsets (bytes)
   localparam logic [31:0] OFS_CORE_ON   = 32'h00;
   localparam logic [31:0] OFS_CORE_OFF  = 32'h04;
   localparam logic [31:0] OFS_CORE_STAT = 32'h08;
   localparam logic [31:0] OFS_PER_ON    = 32'h10;
   localparam logic [31:0] OFS_PER_OFF   = 32'h14;
   localparam logic [31:0] OFS_PER_STAT  = 32'h18;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CORE_ON,
      SEL_CORE_OFF,
      SEL_CORE_STAT,
      SEL_PER_ON,
      SEL_PER_OFF,
      SEL_PER_STAT
   } cgc_sel_e;

   function automatic cgc_sel_e cgc_decode(input logic [31:0] ofs);
      cgc_sel_e sel;
      case (ofs)
         OFS_CORE_ON:   sel = SEL_CORE_ON;
         OFS_CORE_OFF:  sel = SEL_CORE_OFF;
         OFS_CORE_STAT: sel = SEL_CORE_STAT;
         OFS_PER_ON:    sel = SEL_PER_ON;
         OFS_PER_OFF:   sel = SEL_PER_OFF;
         OFS_PER_STAT:  sel = SEL_PER_STAT;
         default:       sel = SEL_NONE;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/cgc_regif.sv
module cgc_regif
   import cgc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_PERIPH = 16
) (
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic                  core_en,
   input  logic                  core_pend,
   input  logic [NUM_PERIPH-1:0] per_en,
   output logic                  core_on_req,
   output logic                  core_off_req,
   output logic [NUM_PERIPH-1:0] per_on_mask,
   output logic [NUM_PERIPH-1:0] per_off_mask
);

   cgc_sel_e sel;

   assign sel = cgc_decode(32'(bus_addr));

   // Write side: only ones in the data act
   assign core_on_req  = bus_wr && (sel == SEL_CORE_ON)  && bus_wdata[0];
   assign core_off_req = bus_wr && (sel == SEL_CORE_OFF) && bus_wdata[0];
   assign per_on_mask  = (bus_wr && (sel == SEL_PER_ON))  ? bus_wdata[NUM_PERIPH-1:0] : '0;
   assign per_off_mask = (bus_wr && (sel == SEL_PER_OFF)) ? bus_wdata[NUM_PERIPH-1:0] : '0;

   // Upper data bits carry nothing
   generate
      if (DATA_W > NUM_PERIPH) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^bus_wdata[DATA_W-1:NUM_PERIPH];
      end
   endgenerate

   // Read side: status only, zero elsewhere
   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (sel)
            SEL_CORE_STAT: bus_rdata = DATA_W'({core_pend, core_en});
            SEL_PER_STAT:  bus_rdata = DATA_W'(per_en);
            default:       bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/cgc_core_ctl.sv
module cgc_core_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic on_req,
   input  logic off_req,
   input  logic irq_req,
   input  logic insn_done,
   output logic core_en,
   output logic stop_pend
);

   logic core_en_q, pend_q;
   logic core_en_d, pend_d;

   // Priority: wake, explicit enable, boundary stop, new request
   always_comb begin
      core_en_d = core_en_q;
      pend_d    = pend_q;
      if (irq_req || on_req) begin
         core_en_d = 1'b1;
         pend_d    = 1'b0;
      end else if (pend_q && insn_done) begin
         core_en_d = 1'b0;
         pend_d    = 1'b0;
      end else if (off_req && core_en_q) begin
         pend_d    = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_en_q <= 1'b1;
         pend_q    <= 1'b0;
      end else begin
         core_en_q <= core_en_d;
         pend_q    <= pend_d;
      end
   end

   assign core_en   = core_en_q;
   assign stop_pend = pend_q;

   assert_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> (core_en && !stop_pend));

   assert_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      on_req |=> (core_en && !stop_pend));

   assert_stop_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_en) |-> $past(stop_pend && insn_done));

   assert_pend_while_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pend |-> core_en);

endmodule

// File: rtl/cgc_periph_bank.sv
module cgc_periph_bank #(
   parameter int unsigned NUM_PERIPH = 16,
   parameter int unsigned RSVD_LOW   = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PERIPH-1:0] on_mask,
   input  logic [NUM_PERIPH-1:0] off_mask,
   output logic [NUM_PERIPH-1:0] per_en
);

   generate
      for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_bit
         if (i >= RSVD_LOW) begin : g_impl
            logic en_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  en_q <= 1'b0;
               else if (on_mask[i])
                  en_q <= 1'b1;   // enable wins
               else if (off_mask[i])
                  en_q <= 1'b0;
            end
            assign per_en[i] = en_q;

            assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
               on_mask[i] |=> per_en[i]);

            assert_clear_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
               (off_mask[i] && !on_mask[i]) |=> !per_en[i]);
         end else begin : g_rsvd
            logic unused_rsvd;
            assign unused_rsvd = on_mask[i] ^ off_mask[i];
            assign per_en[i]   = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/clock_gate_ctrl.sv
module clock_gate_ctrl #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_PERIPH = 16,
   parameter int unsigned RSVD_LOW   = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic                  irq_req,
   input  logic                  insn_done,
   output logic                  core_clk_en,
   output logic                  core_stop_pend,
   output logic [NUM_PERIPH-1:0] periph_clk_en
);

   // Elaboration-time parameter checks
   generate
      if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr
         $error("clock_gate_ctrl: ADDR_W must lie in 5..32");
      end
      if (DATA_W < 2 || DATA_W < NUM_PERIPH) begin : g_bad_data
         $error("clock_gate_ctrl: DATA_W must hold NUM_PERIPH and the core status");
      end
      if (NUM_PERIPH < 1 || RSVD_LOW >= NUM_PERIPH) begin : g_bad_per
         $error("clock_gate_ctrl: RSVD_LOW must be below NUM_PERIPH");
      end
   endgenerate

   logic                  core_on_req, core_off_req;
   logic [NUM_PERIPH-1:0] per_on_mask, per_off_mask;

   cgc_regif #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .NUM_PERIPH (NUM_PERIPH)
   ) u_regif (
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .core_en      (core_clk_en),
      .core_pend    (core_stop_pend),
      .per_en       (periph_clk_en),
      .core_on_req  (core_on_req),
      .core_off_req (core_off_req),
      .per_on_mask  (per_on_mask),
      .per_off_mask (per_off_mask)
   );

   cgc_core_ctl u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .on_req    (core_on_req),
      .off_req   (core_off_req),
      .irq_req   (irq_req),
      .insn_done (insn_done),
      .core_en   (core_clk_en),
      .stop_pend (core_stop_pend)
   );

   cgc_periph_bank #(
      .NUM_PERIPH (NUM_PERIPH),
      .RSVD_LOW   (RSVD_LOW)
   ) u_periph (
      .clk      (clk),
      .rst_n    (rst_n),
      .on_mask  (per_on_mask),
      .off_mask (per_off_mask),
      .per_en   (periph_clk_en)
   );

   assert_periph_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((per_on_mask == '0) && (per_off_mask == '0)) |=> $stable(periph_clk_en));

endmodule

// File: tb/test_clock_gate_ctrl.sv
module test_clock_gate_ctrl;

   localparam int unsigned AW = 8;
   localparam int unsigned DW = 32;
   localparam int unsigned NP = 16;
   localparam int unsigned RL = 2;
   localparam logic [NP-1:0] IMPL = {{(NP-RL){1'b1}}, {RL{1'b0}}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_req = 1'b0, insn_done = 1'b0;
   logic          core_clk_en, core_stop_pend;
   logic [NP-1:0] periph_clk_en;

   int n_run = 0;
   int n_fail = 0;

   // model state
   logic          m_core = 1'b1;
   logic          m_pend = 1'b0;
   logic [NP-1:0] m_per = '0;

   always #5 clk = ~clk;

   clock_gate_ctrl #(.ADDR_W(AW), .DATA_W(DW), .NUM_PERIPH(NP), .RSVD_LOW(RL)) i_clock_gate_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req), .insn_done(insn_done),
      .core_clk_en(core_clk_en), .core_stop_pend(core_stop_pend), .periph_clk_en(periph_clk_en)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic rd, input logic [7:0] a,
                                            input logic c, input logic p, input logic [NP-1:0] per);
      if (!rd) return 32'h0;
      case (a)
         8'h08:   return {30'h0, p, c};
         8'h18:   return 32'(per);
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [1:0] core_next(input logic c, input logic p, input logic wr,
                                            input logic [7:0] a, input logic d0,
                                            input logic irq, input logic done);
      if (irq || (wr && a == 8'h00 && d0)) return 2'b01;      // {pend, core}
      if (p && done) return 2'b00;
      if (wr && a == 8'h04 && d0 && c) return 2'b11;
      return {p, c};
   endfunction

   function automatic logic [NP-1:0] per_next(input logic [NP-1:0] per, input logic wr,
                                              input logic [7:0] a, input logic [31:0] d);
      if (wr && a == 8'h10) return per | (d[NP-1:0] & IMPL);
      if (wr && a == 8'h14) return per & ~d[NP-1:0];
      return per;
   endfunction

   task automatic step(input logic wr, input logic rd, input logic [7:0] a, input logic [31:0] d,
                       input logic irq, input logic done);
      logic [1:0] cn;
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
      irq_req = irq; insn_done = done;
      #1;
      chk("R7 read data", bus_rdata, exp_read(rd, a, m_core, m_pend, m_per));
      cn     = core_next(m_core, m_pend, wr, a, d[0], irq, done);
      m_per  = per_next(m_per, wr, a, d);
      m_core = cn[0];
      m_pend = cn[1];
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; irq_req = 1'b0; insn_done = 1'b0;
      chk("R2/R3/R4 core_clk_en", 32'(core_clk_en), 32'(m_core));
      chk("R2/R3/R4 core_stop_pend", 32'(core_stop_pend), 32'(m_pend));
      chk("R5/R6/R8/R9 periph_clk_en", 32'(periph_clk_en), 32'(m_per));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [NP-1:0] snap;
      int unsigned seed;
      seed = $urandom(32'd20240611);
      repeat (2) @(negedge clk);
      // R1: values held in reset
      chk("R1 core_clk_en in reset", 32'(core_clk_en), 32'h1);
      chk("R1 core_stop_pend in reset", 32'(core_stop_pend), 32'h0);
      chk("R1 periph_clk_en in reset", 32'(periph_clk_en), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 core_clk_en after reset", 32'(core_clk_en), 32'h1);

      // R8: reserved low positions never set
      step(1, 0, 8'h10, 32'hFFFF_FFFF, 0, 0);
      chk("R8 reserved bits stay clear", 32'(periph_clk_en), 32'h0000_FFFC);
      step(0, 1, 8'h18, 32'h0, 0, 0);
      // R6: immediate clear
      step(1, 0, 8'h14, 32'h0000_00F0, 0, 0);
      chk("R6 clear takes effect next edge", 32'(periph_clk_en), 32'h0000_FF0C);
      // R5: zeros have no effect
      step(1, 0, 8'h10, 32'h0, 0, 0);
      chk("R5 zero write no effect", 32'(periph_clk_en), 32'h0000_FF0C);
      step(1, 0, 8'h10, 32'h0000_0030, 0, 0);
      chk("R5 set selected bits", 32'(periph_clk_en), 32'h0000_FF3C);

      // R3: deferred stop
      snap = periph_clk_en;
      step(1, 0, 8'h04, 32'h1, 0, 1);
      chk("R3 stop pending, core still on", {30'h0, core_stop_pend, core_clk_en}, 32'h3);
      step(0, 0, 8'h00, 32'h0, 0, 0);
      step(0, 0, 8'h00, 32'h0, 0, 0);
      chk("R3 no boundary yet, core still on", 32'(core_clk_en), 32'h1);
      step(0, 1, 8'h08, 32'h0, 0, 1);
      chk("R3 stop at boundary", {30'h0, core_stop_pend, core_clk_en}, 32'h0);
      chk("R9 periph untouched by core stop", 32'(periph_clk_en), 32'(snap));
      step(0, 0, 8'h00, 32'h0, 0, 1);
      chk("R3 done without pend no effect", 32'(core_clk_en), 32'h0);
      // R4: wake
      step(0, 0, 8'h00, 32'h0, 1, 0);
      chk("R4 irq wakes core", 32'(core_clk_en), 32'h1);
      // R4: disable and irq same cycle
      step(1, 0, 8'h04, 32'h1, 1, 0);
      chk("R4 enable wins same cycle", {30'h0, core_stop_pend, core_clk_en}, 32'h1);
      // R4: irq cancels a pending stop even with insn_done
      step(1, 0, 8'h04, 32'h1, 0, 0);
      step(0, 0, 8'h00, 32'h0, 1, 1);
      chk("R4 pending stop cancelled", {30'h0, core_stop_pend, core_clk_en}, 32'h1);
      // R2: explicit enable cancels pending; bit 0 clear ignored
      step(1, 0, 8'h04, 32'h1, 0, 0);
      step(1, 0, 8'h00, 32'hFFFF_FFFE, 0, 0);
      chk("R2 on-write with bit0 clear ignored", 32'(core_stop_pend), 32'h1);
      step(1, 0, 8'h00, 32'h1, 0, 0);
      chk("R2 on-write cancels pending", {30'h0, core_stop_pend, core_clk_en}, 32'h1);
      chk("R9 periph untouched by core traffic", 32'(periph_clk_en), 32'(snap));
      // R7: write registers and reads with bus_rd low read zero
      step(0, 1, 8'h10, 32'h0, 0, 0);
      step(0, 1, 8'h04, 32'h0, 0, 0);
      bus_addr = 8'h18; bus_rd = 1'b0; #1;
      chk("R7 rdata zero with rd low", bus_rdata, 32'h0);

      // constrained random
      for (int k = 0; k < 3000; k++) begin
         logic [7:0] a;
         case ($urandom % 7)
            0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h10;
            4: a = 8'h14; 5: a = 8'h18; default: a = 8'h1C;
         endcase
         step(($urandom % 3) == 0, ($urandom % 2) == 0, a, $urandom,
              ($urandom % 10) == 0, ($urandom % 3) == 0);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule